// File: doc/BRIEF.md
# Switching Clock Selector and Divide-by-22 Timebase

This block provides the switching timebase of a DC/DC converter. It has one mode/sync pin, and that pin has three possible states. If the pin is held low, the converter runs from its internal oscillator (about 13 MHz) and chooses freely between PWM and PFM. If the pin is held high, the internal oscillator still runs the converter, but PWM is forced at every load. If the pin toggles anywhere from 4.5 MHz to 20 MHz, the pin itself becomes the switching clock and PFM is forbidden.

The block works out which of the three cases applies. It counts pin activity over windows of internal-clock cycles. Each pin rising edge advances a small counter clocked by the pin, and the block counts the transitions of that counter's top bit after synchronising it. When the active source changes, a two-stage enable handover lets each source drop out only on its own falling edge. Every high and low phase of the muxed clock therefore has full length. The muxed clock drives a divide-by-22 phase counter. That counter restarts at every source change and gives a one-cycle tick at phase 0 for the switching sequencer.

Top module: `swclk_sel_div`

## Requirements
- R1: While reset is asserted, `phase` is 21, `sw_tick` is 0, `pfm_ok` is 1, `pwm_only` is 0 and `ext_active` is 0.
- R2: With the pin held low, `pfm_ok`=1, `pwm_only`=0 and `ext_active`=0, and `sw_clk` runs at the internal clock period.
- R3: With the pin held high, `pwm_only`=1, `pfm_ok`=0 and `ext_active`=0, and `sw_clk` stays on the internal clock. The flags follow the level within a few internal cycles.
- R4: With the pin toggling at 4.5 to 20 MHz, the block reaches `ext_active`=1, `pwm_only`=1 and `pfm_ok`=0 within three windows, and `sw_clk` then has the pin's period. `pfm_ok` is never 1 while `ext_active` is 1.
- R5: When the pin stops toggling, the block returns to the internal clock after two consecutive windows with no activity. The flags then follow the static level as in R2 and R3. The classification changes only at a window boundary.
- R6: On each rising edge of `sw_clk`, `phase` advances by one through 0..21 and wraps from 21 to 0. `sw_tick` is 1 exactly while `phase` is 0.
- R7: The first `sw_clk` rising edge after reset, and the first one after a source change, brings `phase` to 0.
- R8: No high or low phase of `sw_clk` is shorter than half the period of the faster source. The two sources are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock, about 13 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | Shared pin: static low, static high, or external clock |
| sw_clk | output | 1 | Glitch-free selected clock |
| sw_tick | output | 1 | High for the one `sw_clk` cycle in which phase is 0 |
| phase | output | 5 | Phase count 0..21 within the switching period |
| ext_active | output | 1 | External clock is the active source |
| pwm_only | output | 1 | Sequencer must stay in PWM |
| pfm_ok | output | 1 | Sequencer may choose PFM |

## Verification
The bench goes after the handover instants, in both directions. A mux that switched without waiting for falling edges would give a short high or low pulse on `sw_clk`, and the width monitor catches this. If the divider did not restart, the first tick on the new source would land mid-period, and the per-edge phase model flags the wrong count. The bench uses both the slowest (4.5 MHz) and fastest (20 MHz) external clocks, so a detector that lost edges would never declare the slow clock. The bench also stops the pin both high and low. A handover that waited for a falling edge on a dead pin would stay stuck with no clock and never return to internal. A classifier that ignored the level would report the wrong PWM/PFM flags.

// File: rtl/swclk_sel_div.sv
module swclk_sel_div #(
  parameter int DIV      = 22,
  parameter int WIN_LEN  = 64,
  parameter int EDGE_MIN = 4,
  parameter int PRE_BITS = 3
) (
  input  logic                   clk_int,
  input  logic                   rst_n,
  input  logic                   sync_pin,
  output logic                   sw_clk,
  output logic                   sw_tick,
  output logic [$clog2(DIV)-1:0] phase,
  output logic                   ext_active,
  output logic                   pwm_only,
  output logic                   pfm_ok
);
  localparam int PW = $clog2(DIV);
  localparam int WW = $clog2(WIN_LEN);
  localparam int TW = $clog2(EDGE_MIN + 1);

  logic [PRE_BITS-1:0] pre;
  logic [2:0]          act_s;
  logic [1:0]          lvl_s;
  logic [WW-1:0]       win_cnt;
  logic [TW-1:0]       tr_cnt;
  logic                quiet, is_clk;
  logic [1:0]          ip, ep;
  logic                int_en, ext_en;

  always_ff @(posedge sync_pin or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) begin
      act_s <= '0;
      lvl_s <= '0;
    end else begin
      act_s <= {act_s[1:0], pre[PRE_BITS-1]};
      lvl_s <= {lvl_s[0], sync_pin};
    end

  wire act_edge = act_s[2] ^ act_s[1];
  wire win_end  = (win_cnt == WW'(WIN_LEN - 1));

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      tr_cnt  <= '0;
      quiet   <= 1'b0;
      is_clk  <= 1'b0;
    end else if (win_end) begin
      win_cnt <= '0;
      tr_cnt  <= '0;
      if (tr_cnt >= TW'(EDGE_MIN)) begin
        is_clk <= 1'b1;
        quiet  <= 1'b0;
      end else if (tr_cnt == '0) begin
        if (quiet) is_clk <= 1'b0;
        quiet <= 1'b1;
      end else begin
        quiet <= 1'b0;
      end
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (act_edge && tr_cnt < TW'(EDGE_MIN)) tr_cnt <= tr_cnt + 1'b1;
    end

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) ip <= 2'b11;
    else        ip <= {ip[0], ~is_clk & ~ext_en};

  always_ff @(negedge clk_int or negedge rst_n)
    if (!rst_n) int_en <= 1'b1;
    else        int_en <= ip[1];

  wire ext_clr_n = rst_n & is_clk;

  always_ff @(posedge sync_pin or negedge ext_clr_n)
    if (!ext_clr_n) ep <= '0;
    else            ep <= {ep[0], is_clk & ~int_en};

  always_ff @(negedge sync_pin or negedge ext_clr_n)
    if (!ext_clr_n) ext_en <= 1'b0;
    else            ext_en <= ep[1];

  assign sw_clk = (clk_int & int_en) | (sync_pin & ext_en);

  wire div_rst_n = rst_n & (int_en | ext_en);

  always_ff @(posedge sw_clk or negedge div_rst_n)
    if (!div_rst_n)                  phase <= PW'(DIV - 1);
    else if (phase == PW'(DIV - 1))  phase <= '0;
    else                             phase <= phase + 1'b1;

  assign sw_tick    = (phase == '0);
  assign ext_active = ext_en;
  assign pwm_only   = is_clk | lvl_s[1];
  assign pfm_ok     = ~(is_clk | lvl_s[1]);
endmodule

// File: rtl/swclk_sel_div_chk.sv
module swclk_sel_div_chk #(
  parameter int DIV = 22
) (
  input logic                   clk_int,
  input logic                   rst_n,
  input logic                   int_en,
  input logic                   ext_en,
  input logic                   is_clk,
  input logic                   win_end,
  input logic                   pfm_ok,
  input logic [$clog2(DIV)-1:0] phase
);
  a_r8_one_source: assert property (@(posedge clk_int) disable iff (!rst_n)
    $onehot0({int_en, ext_en}));

  a_r4_pfm_blocked: assert property (@(posedge clk_int) disable iff (!rst_n)
    ext_en |-> !pfm_ok);

  a_r5_class_on_window: assert property (@(posedge clk_int) disable iff (!rst_n)
    !$stable(is_clk) |-> $past(win_end));

  a_r6_phase_range: assert property (@(posedge clk_int) disable iff (!rst_n)
    int'(phase) < DIV);
endmodule

bind swclk_sel_div swclk_sel_div_chk #(.DIV(DIV)) u_chk (
  .clk_int(clk_int), .rst_n(rst_n), .int_en(int_en), .ext_en(ext_en),
  .is_clk(is_clk), .win_end(win_end), .pfm_ok(pfm_ok), .phase(phase)
);

// File: tb/swclk_sel_div_tb.sv
`timescale 1ns/100ps
module swclk_sel_div_tb;
  localparam int  CLK_PERIOD = 77;
  localparam int  DIV        = 22;
  localparam real MIN_HALF   = 24.0;

  logic clk_int = 1'b0;
  logic rst_n   = 1'b0;
  logic sync_pin = 1'b0;
  logic sw_clk, sw_tick, ext_active, pwm_only, pfm_ok;
  logic [4:0] phase;

  int errors = 0;
  int checks = 0;
  int restarts = 0;

  bit  ext_on = 1'b0;
  bit  idle_lvl = 1'b0;
  real ext_half = 25.0;

  swclk_sel_div u_dut (
    .clk_int(clk_int), .rst_n(rst_n), .sync_pin(sync_pin), .sw_clk(sw_clk),
    .sw_tick(sw_tick), .phase(phase), .ext_active(ext_active),
    .pwm_only(pwm_only), .pfm_ok(pfm_ok)
  );

  always #(CLK_PERIOD / 2.0) clk_int = ~clk_int;

  initial forever begin
    if (ext_on) begin
      #(ext_half);
      if (ext_on) sync_pin = ~sync_pin;
    end else begin
      sync_pin = idle_lvl;
      #1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of the phase counter, driven by observed sw_clk edges
  real last_rise, last_fall, prev_iv;
  bit  have_rise = 0, have_fall = 0, have_iv = 0;
  int  exp_ph = DIV - 1;

  always @(posedge sw_clk) begin
    real now, iv;
    bit  rs;
    now = $realtime;
    rs  = 0;
    if (rst_n) begin
      if (have_fall) chk("R8 low width ok", (now - last_fall) >= MIN_HALF, 1);
      if (!have_rise) begin
        exp_ph = 0; rs = 1;
      end else begin
        iv = now - last_rise;
        if (have_iv && iv > 1.15 * prev_iv) begin
          exp_ph = 0; rs = 1;
        end else begin
          exp_ph = (exp_ph + 1) % DIV;
        end
        prev_iv = iv;
        have_iv = 1;
      end
      last_rise = now;
      have_rise = 1;
      #2;
      if (rs) begin
        restarts++;
        chk("R7 phase restarts at 0", int'(phase), exp_ph);
      end else begin
        chk("R6 phase step", int'(phase), exp_ph);
      end
      chk("R6 tick at phase 0", int'(sw_tick), int'(exp_ph == 0));
    end
  end

  always @(negedge sw_clk) begin
    if (rst_n && have_rise) begin
      chk("R8 high width ok", ($realtime - last_rise) >= MIN_HALF, 1);
      last_fall = $realtime;
      have_fall = 1;
    end
  end

  task automatic wait_ns(input int ns);
    #(ns * 1.0);
    @(negedge clk_int);
  endtask

  task automatic start_ext(input real half);
    ext_half = half;
    idle_lvl = sync_pin;
    ext_on   = 1'b1;
  endtask

  task automatic stop_ext(input bit lvl);
    @(sync_pin iff sync_pin == lvl);
    idle_lvl = lvl;
    ext_on   = 1'b0;
  endtask

  task automatic chk_flags(input string req, input int pwm, input int pfm, input int ext);
    chk({req, " pwm_only"}, int'(pwm_only), pwm);
    chk({req, " pfm_ok"}, int'(pfm_ok), pfm);
    chk({req, " ext_active"}, int'(ext_active), ext);
  endtask

  task automatic chk_period(input string req, input int exp_ns);
    chk({req, " sw_clk period ns"}, $rtoi(prev_iv + 0.5), exp_ns);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_int);
    // R1 reset state
    chk("R1 phase", int'(phase), DIV - 1);
    chk("R1 tick", int'(sw_tick), 0);
    chk_flags("R1", 0, 1, 0);
    rst_n = 1'b1;

    wait_ns(20000);
    chk_flags("R2 static low", 0, 1, 0);
    chk_period("R2", CLK_PERIOD);

    idle_lvl = 1'b1;
    wait_ns(2000);
    chk_flags("R3 static high", 1, 0, 0);
    chk_period("R3", CLK_PERIOD);

    idle_lvl = 1'b0;
    wait_ns(1000);
    start_ext(25.0);
    wait_ns(25000);
    chk_flags("R4 20MHz", 1, 0, 1);
    chk_period("R4 20MHz", 50);

    stop_ext(1'b0);
    wait_ns(30000);
    chk_flags("R5 stopped low", 0, 1, 0);
    chk_period("R5 low", CLK_PERIOD);

    start_ext(111.0);
    wait_ns(30000);
    chk_flags("R4 4.5MHz", 1, 0, 1);
    chk_period("R4 4.5MHz", 222);

    stop_ext(1'b1);
    wait_ns(30000);
    chk_flags("R5 stopped high", 1, 0, 0);
    chk_period("R5 high", CLK_PERIOD);

    start_ext(62.5);
    wait_ns(25000);
    chk_flags("R4 8MHz", 1, 0, 1);
    chk_period("R4 8MHz", 125);

    stop_ext(1'b0);
    wait_ns(30000);
    chk_flags("R5 back low", 0, 1, 0);
    chk_period("R5 back", CLK_PERIOD);

    // R7: reset plus six handovers each gave a restart
    chk("R7 restart count", restarts, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule